// File: doc/BRIEF.md
# Management PHY Address Scanner

This block runs once at bring-up to find which Ethernet transceivers answer on a shared management bus. On a start pulse it walks every candidate address from 0 upward. At each address it asks an external management-bus master to read the status register. A transceiver counts as present when the value read back is neither all zeros nor all ones. For each one found, the block records its address in a small table, reads its advertisement register at the same address, and stores that value beside the address.

Reads go out one at a time through a valid/ack request port. The request stays up and unchanged until the master acknowledges it, and the read data is taken in the ack cycle. The scan ends early once the table is full. When no transceiver answers, or when a configuration input says no external transceiver is fitted, entry 0 is loaded with the out-of-range address 32 to mark the built-in transceiver. In the second case no request is issued at all. A one-cycle done pulse marks the end of each run.

Top module: `phy_scan`

## Requirements
- R1: After reset `req_valid`, `done` and `found_cnt` are 0 and every table address and advertisement field is 0.
- R2: Status probes use register number 1 and visit addresses in ascending order from 0. Each request holds `req_valid`, `req_phy` and `req_reg` steady until the cycle in which `req_ack` is high.
- R3: A probe finds a transceiver only when the acknowledged status data is neither 0x0000 nor 0xFFFF. No advertisement read follows an absent address.
- R4: For a present transceiver, its address is written to table entry `found_cnt`. The next request is a read of register 4 at that same address. Its data is stored in the same entry's advertisement field, and `found_cnt` then increases by 1.
- R5: Once `DEPTH` transceivers have been found, no further request is issued, even if addresses remain. `found_cnt` never exceeds `DEPTH`.
- R6: If a full scan up to address 31 finds nothing, `found_cnt` is 0 and entry 0 holds 32.
- R7: If `mii_fitted` is 0 when start is taken, no request is made, entry 0 holds 32, `found_cnt` is 0, and `done` is high in the cycle after the start edge.
- R8: A taken start clears all table entries and `found_cnt`. `done` is high for exactly one cycle per run, in the cycle after the last acknowledged read.
- R9: A start pulse while a scan is in progress is ignored.
- Table packing: entry i's address is `tbl_phy[6*i +: 6]` and its advertisement is `tbl_adv[16*i +: 16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan (taken only when idle) |
| mii_fitted | input | 1 | 1 = external transceivers may be present; 0 = skip scan |
| req_valid | output | 1 | Read request to the management master |
| req_phy | output | 5 | Address being read |
| req_reg | output | 5 | Register number being read (1 or 4) |
| req_ack | input | 1 | Master has completed the read; `rd_data` valid |
| rd_data | input | 16 | Read data, valid with `req_ack` |
| tbl_phy | output | 6*DEPTH | Found addresses, entry i at bits 6i+5..6i |
| tbl_adv | output | 16*DEPTH | Advertisement values, entry i at bits 16i+15..16i |
| found_cnt | output | 6 | Number of transceivers found |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The scan is run against several responder populations. An empty bus where every address answers all ones or zeros exposes whether both rejection values and the fallback to 32 work. A sparse population with a zero-status decoy between two real devices checks appending order and the advertisement pairing. Six devices against a four-entry table check the early stop, and a lone device at address 31 checks the top boundary. A skipped scan and a start pulse issued mid-scan check that runs are isolated and that each run raises done only once.

// File: rtl/phy_scan.sv
module phy_scan #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                mii_fitted,
  output logic                req_valid,
  output logic [4:0]          req_phy,
  output logic [4:0]          req_reg,
  input  logic                req_ack,
  input  logic [DATA_W-1:0]   rd_data,
  output logic [6*DEPTH-1:0]  tbl_phy,
  output logic [DATA_W*DEPTH-1:0] tbl_adv,
  output logic [5:0]          found_cnt,
  output logic                done
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [5:0] DEPTH6 = DEPTH[5:0];
  localparam logic [4:0] REG_STAT = 5'd1;
  localparam logic [4:0] REG_ADV  = 5'd4;
  localparam logic [5:0] NO_PHY   = 6'd32;

  typedef enum logic [1:0] {S_IDLE, S_STAT, S_ADV} st_t;

  st_t               state;
  logic [4:0]        cand;
  logic [5:0]        cnt_q;
  logic              done_q;
  logic [5:0]        phy_q [DEPTH];
  logic [DATA_W-1:0] adv_q [DEPTH];

  wire [IW-1:0] idx       = cnt_q[IW-1:0];
  wire          present   = (rd_data != '0) && (rd_data != '1);
  wire          last_cand = (cand == 5'd31);
  wire          full_next = ((cnt_q + 6'd1) == DEPTH6);

  assign req_valid = (state != S_IDLE);
  assign req_phy   = cand;
  assign req_reg   = (state == S_ADV) ? REG_ADV : REG_STAT;
  assign found_cnt = cnt_q;
  assign done      = done_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign tbl_phy[6*g +: 6]           = phy_q[g];
    assign tbl_adv[DATA_W*g +: DATA_W] = adv_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cand   <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        phy_q[i] <= '0;
        adv_q[i] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          for (int i = 0; i < DEPTH; i++) begin
            phy_q[i] <= '0;
            adv_q[i] <= '0;
          end
          cnt_q <= '0;
          cand  <= '0;
          if (mii_fitted) state <= S_STAT;
          else begin
            phy_q[0] <= NO_PHY;
            done_q   <= 1'b1;
          end
        end
        S_STAT: if (req_ack) begin
          if (present) begin
            phy_q[idx] <= {1'b0, cand};
            state      <= S_ADV;
          end else if (last_cand) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
            if (cnt_q == '0) phy_q[0] <= NO_PHY;
          end else begin
            cand <= cand + 5'd1;
          end
        end
        S_ADV: if (req_ack) begin
          adv_q[idx] <= rd_data;
          cnt_q      <= cnt_q + 6'd1;
          if (full_next || last_cand) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            cand  <= cand + 5'd1;
            state <= S_STAT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ack |=> req_valid && $stable(req_phy) && $stable(req_reg));

  a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ack && req_reg == REG_STAT && !present && !last_cand
    |=> req_valid && req_reg == REG_STAT && req_phy == $past(req_phy) + 5'd1);

  a_r3_absent_no_adv: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ack && req_reg == REG_STAT && !present |=> !(req_valid && req_reg == REG_ADV));

  a_r4_adv_same_phy: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ack && req_reg == REG_STAT && present
    |=> req_valid && req_reg == REG_ADV && req_phy == $past(req_phy));

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    found_cnt <= DEPTH6);

  a_r6_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    done && found_cnt == 6'd0 |-> tbl_phy[5:0] == NO_PHY);

  a_r7_skip: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid && start && !mii_fitted |=> done && !req_valid);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/test_phy_scan.sv
module test_phy_scan;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mii_fitted = 1'b1;
  logic req_valid;
  logic [4:0] req_phy, req_reg;
  logic req_ack = 1'b0;
  logic [15:0] rd_data = '0;
  logic [6*DEPTH-1:0] tbl_phy;
  logic [16*DEPTH-1:0] tbl_adv;
  logic [5:0] found_cnt;
  logic done;

  phy_scan #(.DEPTH(DEPTH), .DATA_W(16)) i_phy_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .mii_fitted(mii_fitted),
    .req_valid(req_valid), .req_phy(req_phy), .req_reg(req_reg),
    .req_ack(req_ack), .rd_data(rd_data), .tbl_phy(tbl_phy),
    .tbl_adv(tbl_adv), .found_cnt(found_cnt), .done(done));

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] stat_mem [32];
  int lat_cnt = 0;
  int log_n = 0;
  logic [4:0] log_phy [80];
  logic [4:0] log_reg [80];
  int done_n = 0;
  int hold_bad = 0;
  logic prev_pend = 1'b0;
  logic [9:0] prev_req = '0;

  function automatic logic [15:0] adv_of(input int p);
    return 16'hA500 | 16'(p);
  endfunction

  // responder: ack two cycles after a request appears, logs each completed read
  always @(posedge clk) begin
    if (req_valid && req_ack) begin
      if (log_n < 80) begin
        log_phy[log_n] <= req_phy;
        log_reg[log_n] <= req_reg;
      end
      log_n   <= log_n + 1;
      req_ack <= 1'b0;
      lat_cnt <= 0;
    end else if (req_valid) begin
      if (lat_cnt == 2) begin
        req_ack <= 1'b1;
        rd_data <= (req_reg == 5'd1) ? stat_mem[req_phy] : adv_of(int'(req_phy));
      end
      lat_cnt <= lat_cnt + 1;
    end else begin
      req_ack <= 1'b0;
      lat_cnt <= 0;
    end
    if (done) done_n <= done_n + 1;
    if (prev_pend && prev_req != {req_phy, req_reg}) hold_bad <= hold_bad + 1;
    prev_pend <= req_valid && !req_ack;
    prev_req  <= {req_phy, req_reg};
  end

  task automatic check(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic set_pop(input logic [31:0] mask, input logic [15:0] absent_val);
    for (int p = 0; p < 32; p++) stat_mem[p] = mask[p] ? (16'h7800 | 16'(p)) : absent_val;
  endtask

  task automatic clear_log;
    @(negedge clk);
    log_n = 0; done_n = 0; hold_bad = 0;
  endtask

  task automatic pulse_start;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done;
    int t = 0;
    while (done_n == 0 && t < 2000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  // compute expected requests and table from the population, then compare
  task automatic check_scan(input string tag);
    int ecnt = 0, en = 0;
    int ephy [DEPTH];
    logic [4:0] ep [80];
    logic [4:0] er [80];
    for (int i = 0; i < DEPTH; i++) ephy[i] = 0;
    for (int p = 0; p < 32 && ecnt < DEPTH; p++) begin
      ep[en] = 5'(p); er[en] = 5'd1; en++;
      if (stat_mem[p] != 16'h0000 && stat_mem[p] != 16'hFFFF) begin
        ephy[ecnt] = p; ep[en] = 5'(p); er[en] = 5'd4; en++; ecnt++;
      end
    end
    if (ecnt == 0) ephy[0] = 32;
    check({tag, " R8 one done"}, done_n, 1);
    check({tag, " R2 hold"}, hold_bad, 0);
    check({tag, " R5 request count"}, log_n, en);
    for (int k = 0; k < en && k < log_n; k++) begin
      check({tag, " R2 phy order"}, log_phy[k], ep[k]);
      check({tag, " R3 reg order"}, log_reg[k], er[k]);
    end
    check({tag, " R4 count"}, found_cnt, ecnt);
    for (int i = 0; i < DEPTH; i++) begin
      check({tag, " R4 table phy"}, tbl_phy[6*i +: 6], ephy[i]);
      check({tag, " R4 table adv"}, tbl_adv[16*i +: 16], (i < ecnt) ? adv_of(ephy[i]) : 0);
    end
  endtask

  task automatic t_reset;
    check("R1 req_valid", req_valid, 0);
    check("R1 done", done, 0);
    check("R1 count", found_cnt, 0);
    check("R1 tbl_phy", tbl_phy, 0);
    check("R1 tbl_adv", tbl_adv, 0);
  endtask

  task automatic t_empty;
    set_pop(32'h0, 16'hFFFF);
    stat_mem[7] = 16'h0000; stat_mem[20] = 16'h0000;
    mii_fitted = 1'b1;
    clear_log; pulse_start; wait_done;
    check_scan("empty R6");
  endtask

  task automatic t_sparse;
    set_pop(32'h0002_0008, 16'hFFFF);
    stat_mem[5] = 16'h0000;
    clear_log; pulse_start; wait_done;
    check_scan("sparse R3");
  endtask

  task automatic t_full;
    set_pop(32'h0000_0257, 16'h0000);
    clear_log; pulse_start; wait_done;
    check_scan("full R5");
  endtask

  task automatic t_top;
    set_pop(32'h8000_0000, 16'hFFFF);
    clear_log; pulse_start; wait_done;
    check_scan("top R2");
  endtask

  task automatic t_skip;
    set_pop(32'h0000_000F, 16'hFFFF);
    clear_log; pulse_start;
    clear_log; pulse_start; wait_done;   // refill the table before the skip
    mii_fitted = 1'b0;
    clear_log;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R7 done next cycle", done, 1);
    @(negedge clk);
    check("R7 done single", done, 0);
    repeat (3) @(negedge clk);
    check("R7 no requests", log_n, 0);
    check("R7 count", found_cnt, 0);
    check("R7 entry0", tbl_phy[5:0], 32);
    check("R8 cleared entry1", tbl_phy[11:6], 0);
    check("R8 cleared adv0", tbl_adv[15:0], 0);
    mii_fitted = 1'b1;
  endtask

  task automatic t_restart;
    set_pop(32'h0010_0401, 16'hFFFF);
    clear_log;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    mii_fitted = 1'b0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    mii_fitted = 1'b1;
    wait_done;
    check_scan("restart R9");
  endtask

  initial begin
    for (int p = 0; p < 32; p++) stat_mem[p] = 16'hFFFF;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_empty;
    t_sparse;
    t_full;
    t_top;
    t_skip;
    t_restart;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule